// File: doc/BRIEF.md
# Shared Trigger and Interrupt Pin Unit

This block manages one shared pin that a configuration bit puts into one of two roles. In trigger mode the pin is an input. It is synchronized and watched for rising edges, falling edges or a held active level. Each accepted event becomes a playback request that carries a sequence number set up in configuration. A software start request competes with the pin: two priority fields decide which of them is granted when both arrive in the same cycle.

In interrupt mode the pin is an open-drain, active-low output. Status flags are captured in sticky bits. Any captured flag that is not masked turns on the pull-down enable. A status read clears the sticky bits, and the pull-down releases once no unmasked flag is left. The downstream sequencer and the pad itself are outside this block.

Top module: `trg_pin_unit`

## Requirements
- R1: After reset, play_req, stop_req, play_from_pin and pin_drive_low are 0, play_seq is 0 and status_q is 0. play_seq is 0 in every cycle where play_req is 0.
- R2: In trigger mode with edge detection (cfg_level_en=0) and cfg_rise_en=1, a low-to-high change on pin_in sets play_req for exactly one cycle, with play_seq=cfg_rise_seq and play_from_pin=1. The request is visible after the third rising clock edge that follows the pin change (two synchronizer stages, then one output register).
- R3: In the same edge mode with cfg_fall_en=1, a high-to-low change on pin_in sets play_req for one cycle with play_seq=cfg_fall_seq, using the same latency as R2. When both enables are set, both edges are detected.
- R4: In edge mode, a pin edge whose enable bit is 0 produces no play_req and no stop_req.
- R5: In level mode (cfg_level_en=1, active level high), play_req stays at 1 with play_seq=cfg_rise_seq for as long as the synchronized pin is high. The edge enables have no effect in this mode. When the pin goes low, stop_req is 1 for one cycle, in the same cycle that play_req drops. The latency is the same as in R2.
- R6: A one-cycle sw_go pulse with no pin event in that cycle gives play_req=1, play_seq=sw_seq and play_from_pin=0 in the next cycle.
- R7: When sw_go and a pin request fall in the same cycle, the pin is granted only if cfg_pin_prio is greater than cfg_sw_prio, compared as unsigned numbers. Otherwise the software request is granted. The request that loses is dropped.
- R8: In interrupt mode (cfg_irq_mode=1), pin activity produces no play_req and no stop_req. pin_drive_low becomes 1 one cycle after a flag_set pulse on any bit whose flag_mask bit is 0.
- R9: A flag whose mask bit is 1 is still recorded in status_q, but it does not assert pin_drive_low.
- R10: A status_rd pulse clears status_q, and pin_drive_low releases in the same cycle. A flag_set bit that arrives in the same cycle as status_rd remains set afterwards.
- R11: In trigger mode, pin_drive_low stays 0 even when unmasked flags are set, and status_q still records those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Raw pin level, asynchronous |
| cfg_irq_mode | input | 1 | 1 = interrupt output, 0 = trigger input |
| cfg_rise_en | input | 1 | Rising-edge trigger enable |
| cfg_fall_en | input | 1 | Falling-edge trigger enable |
| cfg_level_en | input | 1 | Level-sensitive trigger mode |
| cfg_rise_seq | input | SEQ_W | Sequence for a rising edge or a held level |
| cfg_fall_seq | input | SEQ_W | Sequence for a falling edge |
| cfg_pin_prio | input | PRIO_W | Priority of pin requests |
| cfg_sw_prio | input | PRIO_W | Priority of software requests |
| sw_go | input | 1 | Software start pulse |
| sw_seq | input | SEQ_W | Sequence for the software request |
| flag_set | input | NFLAG | Status flag set pulses |
| flag_mask | input | NFLAG | 1 = flag blocked from the pin |
| status_rd | input | 1 | Status read pulse, clears the sticky flags |
| status_q | output | NFLAG | Sticky status flags |
| pin_drive_low | output | 1 | Open-drain pull-down enable |
| play_req | output | 1 | Playback request |
| play_seq | output | SEQ_W | Sequence number of the granted request |
| play_from_pin | output | 1 | 1 = the pin's request was granted |
| stop_req | output | 1 | Stop pulse at the end of a level trigger |

## Verification
The bench sweeps every combination of the edge enables and the level bit. For each combination it checks the requests seen on a rising edge and on a falling edge, at the exact three-cycle latency. A design that swapped the sequence numbers, honoured a disabled edge, or used the edge enables in level mode would show the wrong play_seq, or a play_req where none is expected. All sixteen priority pairs are tried with the pin event and sw_go in the same cycle. If the tie were resolved the wrong way, or the comparison inverted, play_from_pin would flip. All masks are crossed with every single flag, and a set that coincides with a read is tested as well. These cases catch three faults: a mask polarity that is reversed, a read that wipes out a new flag, and a pull-down that stays on after the status is cleared or that turns on in trigger mode.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int SEQ_W_DEF  = 7;
  localparam int PRIO_W_DEF = 2;
  localparam int NFLAG_DEF  = 4;
  localparam int SYNC_DEF   = 2;

  typedef enum logic [1:0] {
    KIND_OFF   = 2'd0,
    KIND_EDGE  = 2'd1,
    KIND_LEVEL = 2'd2
  } trg_kind_t;
endpackage

// File: rtl/trg_sync.sv
module trg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q_now,
  output logic q_prev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], d};
  end

  assign q_now  = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/trg_event.sv
module trg_event
  import trg_pkg::*;
#(
  parameter int SEQ_W = 7
) (
  input  logic             s_now,
  input  logic             s_prev,
  input  logic             irq_mode,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic             level_en,
  input  logic [SEQ_W-1:0] rise_seq,
  input  logic [SEQ_W-1:0] fall_seq,
  output logic             ev_req,
  output logic [SEQ_W-1:0] ev_seq,
  output logic             ev_stop
);
  trg_kind_t kind;
  logic      went_up, went_down;

  assign went_up   = s_now & ~s_prev;
  assign went_down = ~s_now & s_prev;

  always_comb begin
    if (irq_mode)      kind = KIND_OFF;
    else if (level_en) kind = KIND_LEVEL;
    else               kind = KIND_EDGE;
  end

  always_comb begin
    ev_req  = 1'b0;
    ev_seq  = '0;
    ev_stop = 1'b0;
    case (kind)
      KIND_LEVEL: begin
        ev_req  = s_now;
        ev_seq  = s_now ? rise_seq : '0;
        ev_stop = went_down;
      end
      KIND_EDGE: begin
        if (went_up && rise_en) begin
          ev_req = 1'b1;
          ev_seq = rise_seq;
        end else if (went_down && fall_en) begin
          ev_req = 1'b1;
          ev_seq = fall_seq;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trg_arb.sv
module trg_arb #(
  parameter int SEQ_W  = 7,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_req,
  input  logic [SEQ_W-1:0]  ev_seq,
  input  logic              ev_stop,
  input  logic              sw_go,
  input  logic [SEQ_W-1:0]  sw_seq,
  input  logic [PRIO_W-1:0] pin_prio,
  input  logic [PRIO_W-1:0] sw_prio,
  output logic              play_req,
  output logic [SEQ_W-1:0]  play_seq,
  output logic              play_from_pin,
  output logic              stop_req
);
  logic pin_wins;

  assign pin_wins = ev_req && (!sw_go || (pin_prio > sw_prio));

  always_ff @(posedge clk) begin
    if (rst) begin
      play_req      <= 1'b0;
      play_seq      <= '0;
      play_from_pin <= 1'b0;
      stop_req      <= 1'b0;
    end else begin
      play_req      <= ev_req | sw_go;
      play_from_pin <= pin_wins;
      stop_req      <= ev_stop;
      if (pin_wins)   play_seq <= ev_seq;
      else if (sw_go) play_seq <= sw_seq;
      else            play_seq <= '0;
    end
  end
endmodule

// File: rtl/trg_irq.sv
module trg_irq #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_mode,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [NFLAG-1:0] flag_mask,
  input  logic             status_rd,
  output logic [NFLAG-1:0] status_q,
  output logic             drive_low
);
  logic [NFLAG-1:0] status_d;
  logic [NFLAG-1:0] live;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign status_d[i] = flag_set[i] | (status_q[i] & ~status_rd);
    assign live[i]     = status_d[i] & ~flag_mask[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      drive_low <= 1'b0;
    end else begin
      status_q  <= status_d;
      drive_low <= irq_mode & (|live);
    end
  end
endmodule

// File: rtl/trg_pin_unit.sv
module trg_pin_unit
  import trg_pkg::*;
#(
  parameter int SEQ_W       = SEQ_W_DEF,
  parameter int PRIO_W      = PRIO_W_DEF,
  parameter int NFLAG       = NFLAG_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic              cfg_irq_mode,
  input  logic              cfg_rise_en,
  input  logic              cfg_fall_en,
  input  logic              cfg_level_en,
  input  logic [SEQ_W-1:0]  cfg_rise_seq,
  input  logic [SEQ_W-1:0]  cfg_fall_seq,
  input  logic [PRIO_W-1:0] cfg_pin_prio,
  input  logic [PRIO_W-1:0] cfg_sw_prio,
  input  logic              sw_go,
  input  logic [SEQ_W-1:0]  sw_seq,
  input  logic [NFLAG-1:0]  flag_set,
  input  logic [NFLAG-1:0]  flag_mask,
  input  logic              status_rd,
  output logic [NFLAG-1:0]  status_q,
  output logic              pin_drive_low,
  output logic              play_req,
  output logic [SEQ_W-1:0]  play_seq,
  output logic              play_from_pin,
  output logic              stop_req
);
  logic             s_now, s_prev;
  logic             ev_req, ev_stop;
  logic [SEQ_W-1:0] ev_seq;

  trg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q_now(s_now), .q_prev(s_prev)
  );

  trg_event #(.SEQ_W(SEQ_W)) event_i (
    .s_now(s_now), .s_prev(s_prev), .irq_mode(cfg_irq_mode),
    .rise_en(cfg_rise_en), .fall_en(cfg_fall_en), .level_en(cfg_level_en),
    .rise_seq(cfg_rise_seq), .fall_seq(cfg_fall_seq),
    .ev_req(ev_req), .ev_seq(ev_seq), .ev_stop(ev_stop)
  );

  trg_arb #(.SEQ_W(SEQ_W), .PRIO_W(PRIO_W)) arb_i (
    .clk(clk), .rst(rst), .ev_req(ev_req), .ev_seq(ev_seq), .ev_stop(ev_stop),
    .sw_go(sw_go), .sw_seq(sw_seq), .pin_prio(cfg_pin_prio), .sw_prio(cfg_sw_prio),
    .play_req(play_req), .play_seq(play_seq), .play_from_pin(play_from_pin),
    .stop_req(stop_req)
  );

  trg_irq #(.NFLAG(NFLAG)) irq_i (
    .clk(clk), .rst(rst), .irq_mode(cfg_irq_mode), .flag_set(flag_set),
    .flag_mask(flag_mask), .status_rd(status_rd), .status_q(status_q),
    .drive_low(pin_drive_low)
  );
endmodule

// File: rtl/trg_pin_unit_chk.sv
module trg_pin_unit_chk #(
  parameter int SEQ_W = 7,
  parameter int NFLAG = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_irq_mode,
  input logic [NFLAG-1:0] flag_set,
  input logic             status_rd,
  input logic [NFLAG-1:0] status_q,
  input logic             pin_drive_low,
  input logic             play_req,
  input logic [SEQ_W-1:0] play_seq,
  input logic             play_from_pin,
  input logic             stop_req
);
  // R1: no sequence number without a request
  p_idle_seq_r1: assert property (@(posedge clk) disable iff (rst)
    !play_req |-> (play_seq == '0));

  // R5: the stop pulse lasts one cycle
  p_stop_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !stop_req);

  // R8: a granted pin request needs trigger mode in the cycle before
  p_pin_quiet_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (play_req && play_from_pin) |-> !$past(cfg_irq_mode));

  // R8: the pull-down needs a recorded flag
  p_drive_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    pin_drive_low |-> (|status_q));

  // R10: a read with no new flag leaves the status empty
  p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (status_rd && (flag_set == '0)) |=> (status_q == '0) && !pin_drive_low);

  // R11: no pull-down in trigger mode
  p_no_drive_trig_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_irq_mode) |-> !pin_drive_low);
endmodule

bind trg_pin_unit trg_pin_unit_chk #(.SEQ_W(SEQ_W), .NFLAG(NFLAG)) chk_i (
  .clk(clk), .rst(rst), .cfg_irq_mode(cfg_irq_mode), .flag_set(flag_set),
  .status_rd(status_rd), .status_q(status_q), .pin_drive_low(pin_drive_low),
  .play_req(play_req), .play_seq(play_seq), .play_from_pin(play_from_pin),
  .stop_req(stop_req)
);

// File: tb/trg_pin_unit_tb_top.sv
module trg_pin_unit_tb_top;
  localparam int SEQ_W = 7, PRIO_W = 2, NFLAG = 4;
  localparam logic [SEQ_W-1:0] RSEQ = 7'h15, FSEQ = 7'h2A, SSEQ = 7'h33;

  logic clk = 1'b0, rst = 1'b1, pin_in = 1'b0;
  logic cfg_irq_mode = 1'b0, cfg_rise_en = 1'b0, cfg_fall_en = 1'b0, cfg_level_en = 1'b0;
  logic [SEQ_W-1:0] cfg_rise_seq = RSEQ, cfg_fall_seq = FSEQ, sw_seq = SSEQ;
  logic [PRIO_W-1:0] cfg_pin_prio = '0, cfg_sw_prio = '0;
  logic sw_go = 1'b0, status_rd = 1'b0;
  logic [NFLAG-1:0] flag_set = '0, flag_mask = '0;
  logic [NFLAG-1:0] status_q;
  logic pin_drive_low, play_req, play_from_pin, stop_req;
  logic [SEQ_W-1:0] play_seq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trg_pin_unit #(.SEQ_W(SEQ_W), .PRIO_W(PRIO_W), .NFLAG(NFLAG)) dut_i (.*);

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_req(string req, logic r, logic [SEQ_W-1:0] s, logic fp, logic st);
    check(req, {29'd0, play_req, play_from_pin, stop_req}, {29'd0, r, fp, st});
    check(req, {25'd0, play_seq}, {25'd0, s});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk_req("R1", 1'b0, '0, 1'b0, 1'b0);
    check("R1", {31'd0, pin_drive_low}, 32'd0);
    check("R1", {28'd0, status_q}, 32'd0);

    // R2 R3 R4 R5 sweep of enables and level bit
    for (int c = 0; c < 8; c++) begin
      logic le, re, fe;
      le = c[2]; re = c[1]; fe = c[0];
      cfg_level_en = le; cfg_rise_en = re; cfg_fall_en = fe;
      tick(2);
      pin_in = 1'b1;
      tick(2);
      chk_req("R4", 1'b0, '0, 1'b0, 1'b0);       // nothing before latency
      tick();
      if (le) chk_req("R5", 1'b1, RSEQ, 1'b1, 1'b0);
      else if (re) chk_req("R2", 1'b1, RSEQ, 1'b1, 1'b0);
      else chk_req("R4", 1'b0, '0, 1'b0, 1'b0);
      tick();
      if (le) chk_req("R5", 1'b1, RSEQ, 1'b1, 1'b0);
      else chk_req("R2", 1'b0, '0, 1'b0, 1'b0);
      tick(3);
      if (le) chk_req("R5", 1'b1, RSEQ, 1'b1, 1'b0);
      else chk_req("R4", 1'b0, '0, 1'b0, 1'b0);
      pin_in = 1'b0;
      tick(3);
      if (le) chk_req("R5", 1'b0, '0, 1'b0, 1'b1);
      else if (fe) chk_req("R3", 1'b1, FSEQ, 1'b1, 1'b0);
      else chk_req("R4", 1'b0, '0, 1'b0, 1'b0);
      tick();
      chk_req("R5", 1'b0, '0, 1'b0, 1'b0);
    end
    cfg_level_en = 1'b0; cfg_fall_en = 1'b0; cfg_rise_en = 1'b1;

    // R6 software request alone
    sw_go = 1'b1; tick(); sw_go = 1'b0;
    chk_req("R6", 1'b1, SSEQ, 1'b0, 1'b0);
    tick();
    chk_req("R6", 1'b0, '0, 1'b0, 1'b0);

    // R7 all priority pairs with simultaneous events
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        logic pw;
        cfg_pin_prio = p[1:0]; cfg_sw_prio = s[1:0];
        pw = (p > s);
        pin_in = 1'b1;
        tick(2);
        sw_go = 1'b1; tick(); sw_go = 1'b0;
        chk_req("R7", 1'b1, pw ? RSEQ : SSEQ, pw, 1'b0);
        tick();
        chk_req("R7", 1'b0, '0, 1'b0, 1'b0);
        pin_in = 1'b0;
        tick(4);
      end
    end

    // R7 software wins over a held level
    cfg_level_en = 1'b1; cfg_pin_prio = 2'd0; cfg_sw_prio = 2'd1;
    pin_in = 1'b1; tick(4);
    sw_go = 1'b1; tick(); sw_go = 1'b0;
    chk_req("R7", 1'b1, SSEQ, 1'b0, 1'b0);
    tick();
    chk_req("R5", 1'b1, RSEQ, 1'b1, 1'b0);
    pin_in = 1'b0; tick(4);
    cfg_level_en = 1'b0;

    // R11 flags in trigger mode never drive the pin
    flag_set = 4'b0101; tick(); flag_set = '0;
    check("R11", {31'd0, pin_drive_low}, 32'd0);
    check("R11", {28'd0, status_q}, 32'h5);
    tick();
    check("R11", {31'd0, pin_drive_low}, 32'd0);
    status_rd = 1'b1; tick(); status_rd = 1'b0;

    // R8 R9 R10 interrupt mode, all masks times each flag
    cfg_irq_mode = 1'b1; cfg_rise_en = 1'b1; cfg_fall_en = 1'b1;
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < NFLAG; f++) begin
        logic [NFLAG-1:0] fb;
        fb = NFLAG'(1) << f;
        flag_mask = m[NFLAG-1:0];
        flag_set = fb; tick(); flag_set = '0;
        check(m[f] ? "R9" : "R8", {31'd0, pin_drive_low}, {31'd0, ~m[f]});
        check("R9", {28'd0, status_q}, {28'd0, fb});
        status_rd = 1'b1; tick(); status_rd = 1'b0;
        check("R10", {31'd0, pin_drive_low}, 32'd0);
        check("R10", {28'd0, status_q}, 32'd0);
      end
    end

    // R10 set in the same cycle as read survives
    flag_mask = '0;
    flag_set = 4'b0001; tick();
    flag_set = 4'b0010; status_rd = 1'b1; tick();
    flag_set = '0; status_rd = 1'b0;
    check("R10", {28'd0, status_q}, 32'h2);
    check("R10", {31'd0, pin_drive_low}, 32'd1);
    status_rd = 1'b1; tick(); status_rd = 1'b0;

    // R8 pin edges ignored in interrupt mode
    pin_in = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk_req("R8", 1'b0, '0, 1'b0, 1'b0);
    end
    pin_in = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk_req("R8", 1'b0, '0, 1'b0, 1'b0);
    end
    cfg_level_en = 1'b1; pin_in = 1'b1; tick(4);
    chk_req("R8", 1'b0, '0, 1'b0, 1'b0);
    pin_in = 1'b0; tick(4);
    chk_req("R8", 1'b0, '0, 1'b0, 1'b0);

    finish_run();
  end
endmodule